// File: doc/BRIEF.md
# Omega Shuffle-Exchange Routing Network

This block is a purely combinational multistage interconnect with `N` input rows and `N` output rows. `N` is a power of two and defaults to 8. The network has log2(N) columns of 2x2 switches, with `N/2` switches in each column. A fixed perfect-shuffle permutation sits in front of every column. The shuffle maps line `i` to line `2i` when `i < N/2`, and to line `2i+1-N` otherwise. For the default size this gives 12 switches and a depth of 3.

Each input row offers a word made of a valid bit, a destination row index and a data word. The words steer themselves with no central controller. The column numbered k (counting from 1) examines destination bit `log2(N)-k`, so the most significant bit is used first. A 0 sends the word to the switch's upper output and a 1 sends it to the lower output.

When two valid words at one switch ask for the same output, the word on the upper input proceeds. The other word is discarded, and the blocked flag of the input row it came from is raised. The block does not buffer or retry discarded words.

Top module: `omega_net`

## Requirements
- R1: When exactly one input row is valid, its word appears on output row `dest` with its data unchanged, and no blocked flag is set. This holds for every pair of source row and destination.
- R2: An input row whose valid bit is 0 never raises its blocked flag. Any output row that receives no word shows valid 0 and all-zero data.
- R3: Suppose two valid words meet at a switch in column k (k = 1..log2(N)) and ask for the same output. The surviving word is the one whose source row index has bit `log2(N)-k` equal to 0, because that word arrives on the switch's upper input. The other word is dropped, and `blocked` is set at the index of its source row.
- R4: For every input pattern, the number of valid output rows plus the number of set blocked flags equals the number of valid input rows.
- R5: If two valid inputs name the same destination, at least one of them is flagged blocked.
- R6: A full permutation in which every row `i` targets `(i + c) mod N`, for any constant `c`, is delivered with no blocked flag set.
- R7: For every valid input row `i` whose blocked flag is clear, output row `dest_i` is valid and carries `in_data` of row `i`. The destination of row `i` is `in_dest[i*log2(N) +: log2(N)]`. The data of row `i` is `in_data[i*DW +: DW]`. Output row `r` uses `out_data[r*DW +: DW]`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| in_valid | input | N | Valid bit of each input row |
| in_dest | input | N*log2(N) | Destination row index of each input row, one field per row |
| in_data | input | N*DW | Data word of each input row |
| out_valid | output | N | Valid bit of each output row |
| out_data | output | N*DW | Data word delivered to each output row, zero when that row is empty |
| blocked | output | N | Set for each input row whose word was dropped in a contention |

## Verification
A single active word is swept over every pairing of source and destination. This separates wiring or steering-bit errors from contention effects. Cyclic shifts, identity and reversal are full permutations that must pass untouched, while bit-reversed and random permutations provoke real collisions. Those collisions show whether the upper-input priority is applied at the right column. Random partial traffic, some of it with forced shared destinations, exercises idle rows, the zeroing of empty outputs and the count balance between delivered and dropped words.

// File: rtl/omega_net.sv
module omega_net #(
  parameter int N  = 8,
  parameter int DW = 8,
  localparam int LG = $clog2(N)
) (
  input  logic [N-1:0]    in_valid,
  input  logic [N*LG-1:0] in_dest,
  input  logic [N*DW-1:0] in_data,
  output logic [N-1:0]    out_valid,
  output logic [N*DW-1:0] out_data,
  output logic [N-1:0]    blocked
);

  logic [N-1:0]          v, sv, nv, kill;
  logic [N-1:0][LG-1:0]  d, sd, nd, s, ss, ns;
  logic [N-1:0][DW-1:0]  x, sx, nx;

  always_comb begin
    v = in_valid;
    kill = '0;
    sv = '0; sd = '0; sx = '0; ss = '0;
    nv = '0; nd = '0; nx = '0; ns = '0;
    for (int i = 0; i < N; i++) begin
      d[i] = in_dest[i*LG +: LG];
      x[i] = in_data[i*DW +: DW];
      s[i] = LG'(i);
    end
    for (int k = 0; k < LG; k++) begin
      // shuffle in front of every column
      for (int i = 0; i < N; i++) begin
        int j;
        j = (i < N/2) ? 2*i : 2*i + 1 - N;
        sv[j] = v[i]; sd[j] = d[i]; sx[j] = x[i]; ss[j] = s[i];
      end
      nv = '0; nd = '0; nx = '0; ns = '0;
      for (int w = 0; w < N/2; w++) begin
        logic ru, rl;
        ru = sd[2*w][LG-1-k];
        rl = sd[2*w+1][LG-1-k];
        if (sv[2*w]) begin
          nv[2*w+ru] = 1'b1;
          nd[2*w+ru] = sd[2*w];
          nx[2*w+ru] = sx[2*w];
          ns[2*w+ru] = ss[2*w];
        end
        if (sv[2*w+1]) begin
          if (sv[2*w] && (ru == rl)) begin
            kill[ss[2*w+1]] = 1'b1;
          end else begin
            nv[2*w+rl] = 1'b1;
            nd[2*w+rl] = sd[2*w+1];
            nx[2*w+rl] = sx[2*w+1];
            ns[2*w+rl] = ss[2*w+1];
          end
        end
      end
      v = nv; d = nd; x = nx; s = ns;
    end
  end

  assign out_valid = v;
  assign out_data  = x;
  assign blocked   = kill;

  always_comb begin
    // R4
    balance_chk: assert ($countones(out_valid) + $countones(blocked) == $countones(in_valid));
    // R2
    idle_chk: assert ((blocked & ~in_valid) == '0);
    for (int r = 0; r < N; r++) begin
      // R2
      empty_row_chk: assert (out_valid[r] || (out_data[r*DW +: DW] == '0));
    end
    for (int i = 0; i < N; i++) begin
      if (in_valid[i] && !blocked[i]) begin
        // R7
        deliver_chk: assert (out_valid[in_dest[i*LG +: LG]] &&
          (out_data[in_dest[i*LG +: LG]*DW +: DW] == in_data[i*DW +: DW]));
      end
      for (int j = i + 1; j < N; j++) begin
        if (in_valid[i] && in_valid[j] && (in_dest[i*LG +: LG] == in_dest[j*LG +: LG])) begin
          // R5
          shared_dest_chk: assert (blocked[i] || blocked[j]);
        end
      end
    end
  end

endmodule

// File: tb/sim_omega_net.sv
module sim_omega_net;
  localparam int N = 8;
  localparam int DW = 8;
  localparam int LG = $clog2(N);
  localparam int CLK_P = 10;

  logic clk = 0;
  always #(CLK_P/2) clk = ~clk;

  logic [N-1:0]    in_valid = '0;
  logic [N*LG-1:0] in_dest = '0;
  logic [N*DW-1:0] in_data = '0;
  logic [N-1:0]    out_valid, blocked;
  logic [N*DW-1:0] out_data;

  omega_net #(.N(N), .DW(DW)) u0 (
    .in_valid(in_valid), .in_dest(in_dest), .in_data(in_data),
    .out_valid(out_valid), .out_data(out_data), .blocked(blocked)
  );

  int nchk = 0, nfail = 0;
  bit done = 0;
  int t_v[N], t_d[N], t_x[N];

  task automatic check(input string tag, input logic [N*DW-1:0] act, input logic [N*DW-1:0] exp);
    nchk++;
    if (act !== exp) begin
      nfail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // arithmetic model: after column k a word from row i sits on line ((i<<k)|(dest>>(LG-k))) mod N
  task automatic apply(input string tag);
    int alive[N], ln[N];
    logic [N-1:0] ev, eb;
    logic [N*DW-1:0] ed;
    int nv;
    eb = '0; ev = '0; ed = '0; nv = 0;
    for (int i = 0; i < N; i++) begin
      alive[i] = t_v[i];
      nv += t_v[i];
    end
    for (int k = 1; k <= LG; k++) begin
      for (int i = 0; i < N; i++) ln[i] = ((i << k) | (t_d[i] >> (LG - k))) & (N - 1);
      for (int i = 0; i < N; i++)
        for (int j = i + 1; j < N; j++)
          if (alive[i] != 0 && alive[j] != 0 && ln[i] == ln[j]) begin
            int lo;
            lo = (((i >> (LG - k)) & 1) == 0) ? j : i;
            alive[lo] = 0;
            eb[lo] = 1'b1;
          end
    end
    for (int i = 0; i < N; i++)
      if (alive[i] != 0) begin
        ev[t_d[i]] = 1'b1;
        ed[t_d[i]*DW +: DW] = DW'(t_x[i]);
      end
    @(posedge clk);
    #1;
    for (int i = 0; i < N; i++) begin
      in_valid[i] = (t_v[i] != 0);
      in_dest[i*LG +: LG] = LG'(t_d[i]);
      in_data[i*DW +: DW] = DW'(t_x[i]);
    end
    @(negedge clk);
    check({tag, " blocked"}, {{(N*DW-N){1'b0}}, blocked}, {{(N*DW-N){1'b0}}, eb});
    check({tag, "/R7 rows"}, {{(N*DW-N){1'b0}}, out_valid}, {{(N*DW-N){1'b0}}, ev});
    check({tag, "/R7 data"}, out_data, ed);
    check("R4 balance", (N*DW)'($countones(out_valid) + $countones(blocked)), (N*DW)'(nv));
  endtask

  task automatic fill_data();
    for (int i = 0; i < N; i++) t_x[i] = ($urandom & ((1 << DW) - 1) & ~(N - 1)) | i;
  endtask

  task automatic perm_random();
    for (int i = 0; i < N; i++) begin t_v[i] = 1; t_d[i] = i; end
    for (int i = N - 1; i > 0; i--) begin
      int j, tmp;
      j = $urandom_range(i, 0);
      tmp = t_d[i]; t_d[i] = t_d[j]; t_d[j] = tmp;
    end
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      nchk++; nfail++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
      $finish;
    end
  end

  initial begin
    @(negedge clk);
    check("R2 reset rows", {{(N*DW-N){1'b0}}, out_valid}, '0);
    check("R2 reset data", out_data, '0);
    check("R2 reset blocked", {{(N*DW-N){1'b0}}, blocked}, '0);

    for (int i = 0; i < N; i++) begin t_v[i] = 0; t_d[i] = $urandom_range(N-1, 0); end
    fill_data();
    apply("R2 all idle");

    // R1: single word, every source and destination
    for (int src = 0; src < N; src++)
      for (int dst = 0; dst < N; dst++) begin
        for (int i = 0; i < N; i++) begin t_v[i] = (i == src); t_d[i] = $urandom_range(N-1, 0); end
        t_d[src] = dst;
        fill_data();
        apply("R1");
      end

    // R6: cyclic shifts
    for (int c = 0; c < N; c++) begin
      for (int i = 0; i < N; i++) begin t_v[i] = 1; t_d[i] = (i + c) % N; end
      fill_data();
      apply("R6");
    end

    // reversal and bit reversal permutations
    for (int i = 0; i < N; i++) begin t_v[i] = 1; t_d[i] = N - 1 - i; end
    fill_data();
    apply("R3 reversal");
    for (int i = 0; i < N; i++) begin
      int r;
      r = 0;
      for (int b = 0; b < LG; b++) if (((i >> b) & 1) != 0) r |= 1 << (LG - 1 - b);
      t_v[i] = 1; t_d[i] = r;
    end
    fill_data();
    apply("R3 bitrev");

    for (int n = 0; n < 1500; n++) begin
      perm_random();
      fill_data();
      apply("R3 perm");
    end

    // random partial traffic, destinations may repeat
    for (int n = 0; n < 3000; n++) begin
      for (int i = 0; i < N; i++) begin
        t_v[i] = ($urandom_range(99, 0) < 60) ? 1 : 0;
        t_d[i] = $urandom_range(N-1, 0);
      end
      fill_data();
      apply("R3 partial");
    end

    // R5: forced shared destination
    for (int n = 0; n < 500; n++) begin
      int a, b;
      for (int i = 0; i < N; i++) begin
        t_v[i] = $urandom_range(1, 0);
        t_d[i] = $urandom_range(N-1, 0);
      end
      a = $urandom_range(N-1, 0);
      b = (a + 1 + $urandom_range(N-2, 0)) % N;
      t_v[a] = 1; t_v[b] = 1; t_d[b] = t_d[a];
      fill_data();
      apply("R5");
      nchk++;
      if (!(blocked[a] || blocked[b])) begin
        nfail++;
        $display("FAIL R5 actual=blocked %b expected=row %0d or %0d set", blocked, a, b);
      end
    end

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule